// File: doc/BRIEF.md
# STN Panel Timing Generator

This block drives an external monochrome STN LCD panel from a frame buffer that packs one pixel per bit. It reads that buffer through a synchronous memory port with a one-cycle read latency. It puts pixels onto a 1-bit or 4-bit data bus, with the shift clock, a line latch pulse, a frame marker and a polarity-alternate signal alongside them. When the power enable is low, all eight shared pins carry a general-purpose port value instead.

A single state machine runs the line sequence and never stops. After reset it enters S_START, which loads the line address from the start address and moves to S_FETCH.

- S_FETCH issues one read and moves to S_LOAD.
- S_LOAD captures the returned byte, drops the pan bits if this is the first byte of the line, and moves to S_HIGH.
- S_HIGH raises the shift clock and always moves to S_LOW.
- S_LOW lowers the shift clock and consumes one pixel, or four pixels in 4-bit mode. From S_LOW the machine goes to S_GAP when the line's pixels are done, to S_FETCH when the byte is used up, and back to S_HIGH otherwise.
- S_GAP idles for two clocks and then moves to S_LATCH.
- S_LATCH pulses the latch for one clock, moves to the next line (or back to the start address after the last line) and returns to S_FETCH.

The configuration inputs must stay constant while the block runs. Change them only with reset asserted.

Top module: `stn_panel_timer`

## Requirements
- R1: For the first clock after reset is released, pins 7..4 (frame marker, latch, alternate, shift clock) are all low. On the clock after that, a read is issued at the start address.
- R2: In 1-bit mode (cfg_wide=0), pin 0 carries the pixels of each line at the shift-clock falling edges, cfg_width pixels per line. Pixel p of line l is bit 7-((pan+p) mod 8) of the byte at start + l*pitch + (pan+p)/8.
- R3: In 4-bit mode, each falling edge carries four consecutive pixels, with the earliest on pin 3 and the latest on pin 0. The two low pan bits are ignored, and the pixel count per line rounds up to a multiple of four.
- R4: With cfg_invert=1, every pixel driven onto the data pins is inverted. Non-pixel pins are not inverted.
- R5: In 1-bit mode, pins 3..1 follow port_val[3..1].
- R6: The shift clock (pin 4) is never high on two consecutive clocks.
- R7: The latch (pin 6) is high for exactly one clock. It rises no earlier than three clocks after the line's last shift-clock falling edge.
- R8: The frame marker (pin 7) rises after the latch of the last line and falls after the following latch. Exactly cfg_height latches separate two marked latches.
- R9: With cfg_alt_period=N>0, the alternate signal (pin 5) toggles once every N latches.
- R10: With cfg_alt_period=0, the alternate signal toggles once per frame, after the latch of the last line.
- R11: With cfg_power=0, all eight pins equal port_val.
- R12: A read strobe lasts one clock, and every byte of a line is fetched once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_base | input | 16 | Frame buffer start address |
| cfg_pitch | input | 8 | Bytes between line starts |
| cfg_width | input | 8 | Pixels per line |
| cfg_height | input | 8 | Lines per frame (at least 1) |
| cfg_pan | input | 3 | Pixel offset in the first byte of a line |
| cfg_wide | input | 1 | 1 selects the 4-bit data bus |
| cfg_invert | input | 1 | Invert pixel data |
| cfg_alt_period | input | 5 | Alternate toggle period in lines; 0 means once per frame |
| cfg_power | input | 1 | 1 connects the panel signals to the pins |
| port_val | input | 8 | General-purpose port value |
| mem_rd | output | 1 | Read strobe |
| mem_addr | output | 16 | Read address |
| mem_rdata | input | 8 | Read data, one clock after the strobe |
| pins | output | 8 | 7 marker, 6 latch, 5 alternate, 4 shift clock, 3..0 data |

## Verification
The bench rebuilds every line from the data pins at the shift-clock falling edges and compares it pixel by pixel with the buffer contents. It does this for six configurations that mix both bus widths, inversion on and off, pan values of 0, 3, 4, 5 and 7, and widths that do and do not fill whole bytes. A pan of 5 in 4-bit mode tells whether the two low pan bits are truly dropped, and a pan of 7 with 17 pixels checks a line that spans three bytes. Alternate periods of 1, 2, 3 and 5 and the once-per-frame setting tell line counting apart from frame counting. Directed steps cover the reset state and the port fallback.

// File: rtl/stn_pkg.sv
package stn_pkg;
    typedef enum logic [2:0] {
        S_START, S_FETCH, S_LOAD, S_HIGH, S_LOW, S_GAP, S_LATCH
    } seq_state_t;

    localparam int PIN_MARK  = 7;
    localparam int PIN_LATCH = 6;
    localparam int PIN_ALT   = 5;
    localparam int PIN_SCLK  = 4;
endpackage

// File: rtl/stn_seq.sv
module stn_seq
    import stn_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DIM_W  = 8,
    parameter int GAP    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [DIM_W-1:0]  cfg_pitch,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic [2:0]        cfg_pan,
    input  logic              cfg_wide,
    input  logic [7:0]        mem_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              sclk,
    output logic [3:0]        pix,
    output logic              line_strobe,
    output logic              last_line
);
    localparam int CNT_W = DIM_W + 1;
    localparam int GAP_W = $clog2(GAP + 1);

    seq_state_t        state;
    logic [DIM_W-1:0]  line_idx;
    logic [DIM_W-1:0]  byte_idx;
    logic [ADDR_W-1:0] line_addr;
    logic [CNT_W-1:0]  pix_cnt;
    logic [3:0]        bits_left;
    logic [7:0]        sh;
    logic [GAP_W-1:0]  gap_cnt;

    logic [3:0]        step;
    logic [2:0]        eff_pan;
    logic [CNT_W-1:0]  pix_next;
    logic              first_byte;

    assign step       = cfg_wide ? 4'd4 : 4'd1;
    assign eff_pan    = cfg_wide ? {cfg_pan[2], 2'b00} : cfg_pan;
    assign pix_next   = pix_cnt + CNT_W'(step);
    assign first_byte = (byte_idx == '0);
    assign last_line  = (line_idx == cfg_height - DIM_W'(1));

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_START;
            line_idx  <= '0;
            byte_idx  <= '0;
            line_addr <= '0;
            pix_cnt   <= '0;
            bits_left <= '0;
            sh        <= '0;
            gap_cnt   <= '0;
        end else begin
            unique case (state)
                S_START: begin
                    line_addr <= cfg_base;
                    line_idx  <= '0;
                    state     <= S_FETCH;
                end
                S_FETCH: state <= S_LOAD;
                S_LOAD: begin
                    sh        <= first_byte ? (mem_rdata << eff_pan) : mem_rdata;
                    bits_left <= first_byte ? 4'(4'd8 - {1'b0, eff_pan}) : 4'd8;
                    byte_idx  <= byte_idx + DIM_W'(1);
                    state     <= S_HIGH;
                end
                S_HIGH: state <= S_LOW;
                S_LOW: begin
                    sh        <= sh << step;
                    bits_left <= bits_left - step;
                    pix_cnt   <= pix_next;
                    if (pix_next >= CNT_W'(cfg_width)) begin
                        gap_cnt <= '0;
                        state   <= S_GAP;
                    end else if (bits_left == step) begin
                        state <= S_FETCH;
                    end else begin
                        state <= S_HIGH;
                    end
                end
                S_GAP: begin
                    gap_cnt <= gap_cnt + GAP_W'(1);
                    if (gap_cnt == GAP_W'(GAP - 1)) state <= S_LATCH;
                end
                S_LATCH: begin
                    byte_idx <= '0;
                    pix_cnt  <= '0;
                    if (last_line) begin
                        line_idx  <= '0;
                        line_addr <= cfg_base;
                    end else begin
                        line_idx  <= line_idx + DIM_W'(1);
                        line_addr <= line_addr + ADDR_W'(cfg_pitch);
                    end
                    state <= S_FETCH;
                end
                default: state <= S_START;
            endcase
        end
    end

    // Output decode
    always_comb begin
        mem_rd      = 1'b0;
        sclk        = 1'b0;
        line_strobe = 1'b0;
        mem_addr    = line_addr + ADDR_W'(byte_idx);
        pix         = sh[7:4];
        unique case (state)
            S_FETCH: mem_rd      = 1'b1;
            S_HIGH:  sclk        = 1'b1;
            S_LATCH: line_strobe = 1'b1;
            default: ;
        endcase
    end

    // R6: the shift clock high phase is one clock long
    a_r6_sclk_single: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !sclk);
    // R7: the latch pulse is one clock wide
    a_r7_latch_single: assert property (@(posedge clk) disable iff (!rst_n)
        line_strobe |=> !line_strobe);
    // R7: a falling shift clock is never followed at once by the latch
    a_r7_gap_before_latch: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> !line_strobe);
    // R12: a read strobe lasts one clock
    a_r12_read_single: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);
    // R6: pixel data holds across the falling edge of the shift clock
    a_r6_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> $stable(pix));
endmodule

// File: rtl/stn_polarity.sv
module stn_polarity #(
    parameter int PER_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             line_strobe,
    input  logic             last_line,
    input  logic [PER_W-1:0] period,
    output logic             mark,
    output logic             alt
);
    logic [PER_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mark <= 1'b0;
            alt  <= 1'b0;
            cnt  <= '0;
        end else if (line_strobe) begin
            mark <= last_line;
            if (period == '0) begin
                cnt <= '0;
                if (last_line) alt <= ~alt;
            end else if (cnt == period - PER_W'(1)) begin
                cnt <= '0;
                alt <= ~alt;
            end else begin
                cnt <= cnt + PER_W'(1);
            end
        end
    end

    // R8: the frame marker changes only after a latch
    a_r8_mark_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !line_strobe |=> $stable(mark));
    // R9: the alternate signal changes only after a latch
    a_r9_alt_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
        !line_strobe |=> $stable(alt));
    // R10: in frame mode, a toggle follows only the last line's latch
    a_r10_frame_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (line_strobe && period == '0 && !last_line) |=> $stable(alt));
endmodule

// File: rtl/stn_pin_mux.sv
module stn_pin_mux
    import stn_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             power,
    input  logic             wide,
    input  logic             invert,
    input  logic             mark,
    input  logic             latch,
    input  logic             alt,
    input  logic             sclk,
    input  logic [LANES-1:0] pix,
    input  logic [7:0]       port_val,
    output logic [7:0]       pins
);
    logic [LANES-1:0] lane;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            if (i == 0) begin : g_first
                assign lane[i] = (wide ? pix[0] : pix[LANES-1]) ^ invert;
            end else begin : g_rest
                assign lane[i] = wide ? (pix[i] ^ invert) : port_val[i];
            end
        end
    endgenerate

    always_comb begin
        if (power) begin
            pins              = '0;
            pins[PIN_MARK]    = mark;
            pins[PIN_LATCH]   = latch;
            pins[PIN_ALT]     = alt;
            pins[PIN_SCLK]    = sclk;
            pins[LANES-1:0]   = lane;
        end else begin
            pins = port_val;
        end
    end
endmodule

// File: rtl/stn_panel_timer.sv
module stn_panel_timer #(
    parameter int ADDR_W = 16,
    parameter int DIM_W  = 8,
    parameter int PER_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [DIM_W-1:0]  cfg_pitch,
    input  logic [DIM_W-1:0]  cfg_width,
    input  logic [DIM_W-1:0]  cfg_height,
    input  logic [2:0]        cfg_pan,
    input  logic              cfg_wide,
    input  logic              cfg_invert,
    input  logic [PER_W-1:0]  cfg_alt_period,
    input  logic              cfg_power,
    input  logic [7:0]        port_val,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [7:0]        pins
);
    logic       sclk;
    logic [3:0] pix;
    logic       line_strobe;
    logic       last_line;
    logic       mark;
    logic       alt;

    stn_seq #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .GAP(2)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_base(cfg_base), .cfg_pitch(cfg_pitch), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .cfg_pan(cfg_pan), .cfg_wide(cfg_wide),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .sclk(sclk), .pix(pix), .line_strobe(line_strobe), .last_line(last_line)
    );

    stn_polarity #(.PER_W(PER_W)) u_pol (
        .clk(clk), .rst_n(rst_n), .line_strobe(line_strobe),
        .last_line(last_line), .period(cfg_alt_period),
        .mark(mark), .alt(alt)
    );

    stn_pin_mux #(.LANES(4)) u_mux (
        .power(cfg_power), .wide(cfg_wide), .invert(cfg_invert),
        .mark(mark), .latch(line_strobe), .alt(alt), .sclk(sclk),
        .pix(pix), .port_val(port_val), .pins(pins)
    );
endmodule

// File: tb/stn_panel_timer_test.sv
`timescale 1ns/1ps
module stn_panel_timer_test;
    typedef struct packed {
        logic        wide;
        logic        inv;
        logic [2:0]  pan;
        logic [4:0]  alt;
        logic [7:0]  width;
        logic [7:0]  height;
        logic [7:0]  pitch;
        logic [15:0] base;
    } cfg_t;

    localparam int NV = 6;
    localparam cfg_t VEC [NV] = '{
        '{1'b0, 1'b0, 3'd0, 5'd1, 8'd24, 8'd6, 8'd4, 16'h0100},
        '{1'b0, 1'b1, 3'd3, 5'd3, 8'd20, 8'd5, 8'd5, 16'h0200},
        '{1'b1, 1'b0, 3'd0, 5'd2, 8'd32, 8'd4, 8'd6, 16'h0300},
        '{1'b1, 1'b1, 3'd5, 5'd0, 8'd28, 8'd5, 8'd5, 16'h0400},
        '{1'b0, 1'b0, 3'd7, 5'd0, 8'd17, 8'd3, 8'd4, 16'h0050},
        '{1'b1, 1'b0, 3'd4, 5'd5, 8'd16, 8'd7, 8'd3, 16'h0600}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst_n = 1'b0;
    cfg_t        cfg = VEC[0];
    logic        power = 1'b1;
    logic [7:0]  port_val = 8'h00;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  pins;
    logic        mon_en = 1'b0;

    int nchk = 0;
    int nbad = 0;

    stn_panel_timer uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_base(cfg.base), .cfg_pitch(cfg.pitch), .cfg_width(cfg.width),
        .cfg_height(cfg.height), .cfg_pan(cfg.pan), .cfg_wide(cfg.wide),
        .cfg_invert(cfg.inv), .cfg_alt_period(cfg.alt), .cfg_power(power),
        .port_val(port_val), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .pins(pins)
    );

    logic [7:0] mem [4096];
    initial for (int i = 0; i < 4096; i++) mem[i] = 8'(((i * 37) + (i >> 4)) ^ 'h5A);
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_count();
        return cfg.wide ? ((int'(cfg.width) + 3) / 4) * 4 : int'(cfg.width);
    endfunction

    function automatic int eff_pan();
        return cfg.wide ? int'({cfg.pan[2], 2'b00}) : int'(cfg.pan);
    endfunction

    // Monitor: rebuilds lines and frames from the pins
    bit prev_sclk, prev_latch, prev_alt, prev_rd, synced, had_tog;
    int since_fall, pcnt, line, lat_cnt, last_tog, frames;
    bit pix [256];

    always @(negedge clk) begin
        if (!rst_n || !mon_en) begin
            prev_sclk = 0; prev_latch = 0; prev_alt = 0; prev_rd = 0;
            synced = 0; had_tog = 0; since_fall = 0; pcnt = 0; line = 0;
            lat_cnt = 0; last_tog = 0; frames = 0;
        end else begin
            if (prev_sclk) check(!pins[4], "R6 sclk high twice", int'(pins[4]), 0);
            if (prev_rd) check(!mem_rd, "R12 read strobe long", int'(mem_rd), 0);
            if (prev_sclk && !pins[4]) begin
                since_fall = 0;
                if (!cfg.wide) begin
                    pix[pcnt[7:0]] = pins[0];
                    pcnt++;
                    check(pins[3:1] == port_val[3:1], "R5 idle lanes", int'(pins[3:1]), int'(port_val[3:1]));
                end else begin
                    for (int k = 3; k >= 0; k--) begin
                        pix[pcnt[7:0]] = pins[k];
                        pcnt++;
                    end
                end
            end else begin
                since_fall++;
            end
            if (pins[6]) begin
                check(!prev_latch, "R7 latch width", 2, 1);
                check(since_fall >= 3, "R7 gap before latch", since_fall, 3);
                lat_cnt++;
                if (pins[7]) begin
                    if (synced) check(line == int'(cfg.height), "R8 lines per frame", line, int'(cfg.height));
                    synced = 1;
                    line = 0;
                    frames++;
                end
                if (synced) begin
                    int bad;
                    bad = -1;
                    check(pcnt == exp_count(), "R2 R3 pixel count", pcnt, exp_count());
                    for (int p = 0; p < exp_count(); p++) begin
                        int bp, a;
                        logic e;
                        bp = eff_pan() + p;
                        a = int'(cfg.base) + line * int'(cfg.pitch) + bp / 8;
                        e = mem[a[11:0]][7 - (bp % 8)] ^ cfg.inv;
                        if (pix[p[7:0]] != e && bad < 0) bad = p;
                    end
                    check(bad < 0, cfg.inv ? "R4 inverted line" : (cfg.wide ? "R3 wide line" : "R2 narrow line"), bad, -1);
                    line++;
                end
                pcnt = 0;
            end
            if (pins[5] != prev_alt) begin
                if (had_tog && synced) begin
                    int want;
                    want = (cfg.alt == 0) ? int'(cfg.height) : int'(cfg.alt);
                    check(lat_cnt - last_tog == want, (cfg.alt == 0) ? "R10 frame toggle" : "R9 line toggle",
                          lat_cnt - last_tog, want);
                end
                had_tog = 1;
                last_tog = lat_cnt;
            end
            prev_sclk = pins[4];
            prev_latch = pins[6];
            prev_alt = pins[5];
            prev_rd = mem_rd;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        // R1: reset state and first fetch
        cfg = VEC[0];
        power = 1'b1;
        port_val = 8'hF0;
        do_reset();
        check(pins[7:4] == 4'h0, "R1 control pins after reset", int'(pins[7:4]), 0);
        @(negedge clk);
        check(mem_rd && mem_addr == cfg.base, "R1 first fetch", int'(mem_addr), int'(cfg.base));

        // Configuration table walk
        for (int v = 0; v < NV; v++) begin
            cfg = VEC[v];
            port_val = 8'h0A ^ 8'(v);
            do_reset();
            mon_en = 1'b1;
            for (int c = 0; c < 20000 && frames < 3; c++) @(negedge clk);
            check(frames >= 3, "R8 frames seen", frames, 3);
            mon_en = 1'b0;
            @(negedge clk);
        end

        // R11: port fallback while the sequencer keeps running
        cfg = VEC[2];
        do_reset();
        power = 1'b0;
        port_val = 8'hA5;
        repeat (40) begin
            @(negedge clk);
            check(pins == port_val, "R11 port fallback", int'(pins), int'(port_val));
        end
        port_val = 8'h3C;
        repeat (2) @(negedge clk);
        check(pins == 8'h3C, "R11 port follows", int'(pins), 'h3C);

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++;
        nbad++;
        $display("FAIL watchdog R8 actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule